// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of up to five software localities owns a shared command interface at any moment. Each locality reaches the block through its own 4 KB register window. Every window has a control register. Writing 1 to one of its bits asks for ownership, and writing 1 to another gives ownership up. Every window can also read a shared state register. That register shows the active locality, whether the reading window is the one that owns the interface, and whether the state contents can be trusted.

Only one locality owns the interface at a time. When ownership is free, the lowest-numbered pending requester is chosen. The grant enable and the locality index appear on dedicated outputs, which feed the command-buffer controller next to this block. Register reads are combinational from the address. Writes are sampled on the rising clock edge.

Top module: `loc_owner_arb`

## Requirements
- R1: After reset, `grant_en` is 0, no request is pending, and the state register reads 0x80 from every valid window (active index 0, not assigned, valid set).
- R2: Address bits [14:12] select the window and bits [11:0] give the offset. The control register is at offset 0x008 and the state register is at offset 0x000. Writes to windows 5 to 7, to the state offset or to any other offset have no effect. Reads of windows 5 to 7 and of any offset other than the state offset return 0.
- R3: When ownership is free and the valid flag is high, a request (control bit 0 written as 1) sets that window's pending request at the write edge. The grant is then made at the next edge, so `grant_en` is 1 and `grant_loc` equals the window after the second rising edge. `grant_loc` is always below 5 while `grant_en` is 1.
- R4: When several requests are pending at a grant, the lowest-numbered locality is granted.
- R5: A relinquish (control bit 1 written as 1) from the owner clears `grant_en` and the assigned flag at the edge that samples the write.
- R6: A request made while another locality owns the interface stays pending. After the owner relinquishes, it is granted at the second edge after the release edge.
- R7: A relinquish from a locality that is not the owner withdraws that locality's pending request. A request written by the current owner is ignored and leaves nothing pending.
- R8: State register layout: bits [4:2] give the active locality (0 when no owner), bit 1 is the assigned flag (set only when the reading window is the owner), bit 7 is the valid flag, and all other bits are 0.
- R9: The valid flag is 0 for exactly the one cycle after each grant or release edge and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, sampled at the clock edge |
| addr | input | 15 | Window index [14:12] and register offset [11:0] |
| wdata | input | 8 | Write data; bit 0 requests, bit 1 relinquishes |
| rdata | output | 32 | Combinational read data for `addr` |
| grant_en | output | 1 | A locality currently owns the interface |
| grant_loc | output | 3 | Index of the owning locality, 0 when none |

## Verification
A stale pending bit shows up as an unexpected grant two edges after the interface becomes free. A lost pending bit shows up as `grant_en` staying low when a grant is due. A wrong priority shows up as the wrong `grant_loc` on the very first cycle of the grant. A missing or doubled valid-flag drop is visible at bit 7 of the state register on the cycle right after each ownership change. The wrong-owner and out-of-range cases are caught by reading the state register, and by confirming that no grant follows within three cycles.

// File: rtl/loc_owner_arb.sv
module loc_owner_arb #(
  parameter int NUM_LOC   = 5,
  parameter int WIN_BITS  = 12,
  parameter int CTRL_OFS  = 'h008,
  parameter int STATE_OFS = 'h000,
  localparam int IDX_W    = 3,
  localparam int ADDR_W   = WIN_BITS + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [31:0]       rdata,
  output logic              grant_en,
  output logic [IDX_W-1:0]  grant_loc
);

  logic [IDX_W-1:0]    win;
  logic [WIN_BITS-1:0] ofs;
  logic                win_ok, ctrl_wr, state_hit, is_owner, rel_own;
  logic [NUM_LOC-1:0]  req_q;
  logic                own_q, chg_q;
  logic [IDX_W-1:0]    loc_q, pick;
  logic                pick_vld, grant_now, reg_valid;

  assign win       = addr[ADDR_W-1:WIN_BITS];
  assign ofs       = addr[WIN_BITS-1:0];
  assign win_ok    = 32'(win) < NUM_LOC;
  assign ctrl_wr   = wr_en && win_ok && (ofs == WIN_BITS'(CTRL_OFS));
  assign state_hit = win_ok && (ofs == WIN_BITS'(STATE_OFS));
  assign is_owner  = own_q && (loc_q == win);
  assign rel_own   = ctrl_wr && wdata[1] && is_owner;
  assign reg_valid = !chg_q;

  always_comb begin
    pick = '0;
    for (int i = NUM_LOC - 1; i >= 0; i--)
      if (req_q[i]) pick = IDX_W'(i);
  end

  assign pick_vld  = |req_q;
  assign grant_now = !own_q && pick_vld && !chg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      own_q <= 1'b0;
      loc_q <= '0;
      chg_q <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (rel_own) begin
        own_q <= 1'b0;
        loc_q <= '0;
        chg_q <= 1'b1;
      end else if (grant_now) begin
        own_q      <= 1'b1;
        loc_q      <= pick;
        chg_q      <= 1'b1;
        req_q[pick] <= 1'b0;
      end
      if (ctrl_wr) begin
        if (wdata[0] && !is_owner && !(grant_now && pick == win))
          req_q[win] <= 1'b1;
        if (wdata[1])
          req_q[win] <= 1'b0;
      end
    end
  end

  assign grant_en  = own_q;
  assign grant_loc = own_q ? loc_q : '0;
  assign rdata     = state_hit ? {24'b0, reg_valid, 2'b0, grant_loc, is_owner, 1'b0} : 32'b0;

  // R3
  loc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_en |-> (32'(grant_loc) < NUM_LOC));

  // R3
  free_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_en && reg_valid && (|req_q)) |=> grant_en);

  // R4
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_en) |-> (($past(req_q) & ((NUM_LOC'(1) << grant_loc) - NUM_LOC'(1))) == '0));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_own |=> !grant_en);

  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(grant_en) || $fell(grant_en)) |-> !reg_valid);

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_valid |=> reg_valid);

endmodule

// File: tb/test_loc_owner_arb.sv
module test_loc_owner_arb;
  localparam int CTRL  = 'h008;
  localparam int STATE = 'h000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [14:0] addr;
  logic [7:0]  wdata;
  logic [31:0] rdata;
  logic        grant_en;
  logic [2:0]  grant_loc;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  loc_owner_arb #(.NUM_LOC(5), .WIN_BITS(12), .CTRL_OFS(CTRL), .STATE_OFS(STATE)) i_loc_owner_arb (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .grant_en(grant_en), .grant_loc(grant_loc));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int w, input int o, input logic [7:0] d);
    @(negedge clk);
    addr = {3'(w), 12'(o)}; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int w, input int o, output logic [31:0] v);
    addr = {3'(w), 12'(o)};
    #1 v = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 grant_en", 32'(grant_en), 0);
    rd(0, STATE, v); check("R1 state win0", v, 32'h80);
    rd(4, STATE, v); check("R1 state win4", v, 32'h80);
  endtask

  task automatic t_single();
    logic [31:0] v;
    wr(2, CTRL, 8'h01);
    check("R3 not yet granted", 32'(grant_en), 0);
    @(negedge clk);
    check("R3 grant_en", 32'(grant_en), 1);
    check("R3 grant_loc", 32'(grant_loc), 2);
    rd(2, STATE, v); check("R9 valid low after grant", v, 32'h0A);
    @(negedge clk);
    rd(2, STATE, v); check("R8 owner view", v, 32'h8A);
    rd(0, STATE, v); check("R8 other view", v, 32'h88);
    wr(2, CTRL, 8'h02);
    check("R5 released", 32'(grant_en), 0);
    rd(2, STATE, v); check("R5 assigned clear, R9 valid low", v, 32'h00);
    @(negedge clk);
    rd(2, STATE, v); check("R9 valid back", v, 32'h80);
  endtask

  task automatic release_and_expect(input int owner, input int nxt);
    wr(owner, CTRL, 8'h02);
    check("R6 free after release", 32'(grant_en), 0);
    @(negedge clk);
    check("R6 gap cycle", 32'(grant_en), 0);
    @(negedge clk);
    if (nxt < 0) check("R6 stays free", 32'(grant_en), 0);
    else begin
      check("R6 grant after release", 32'(grant_en), 1);
      check("R4 lowest pending", 32'(grant_loc), 32'(nxt));
    end
  endtask

  task automatic t_priority();
    wr(0, CTRL, 8'h01);
    @(negedge clk);
    check("R3 owner 0", 32'(grant_loc), 0);
    wr(4, CTRL, 8'h01);
    wr(1, CTRL, 8'h01);
    wr(3, CTRL, 8'h01);
    check("R6 owner kept", 32'(grant_en), 1);
    release_and_expect(0, 1);
    release_and_expect(1, 3);
    release_and_expect(3, 4);
    release_and_expect(4, -1);
  endtask

  task automatic t_nonowner();
    wr(1, CTRL, 8'h01);
    @(negedge clk);
    check("R3 owner 1", 32'(grant_loc), 1);
    wr(3, CTRL, 8'h01);
    wr(2, CTRL, 8'h01);
    wr(2, CTRL, 8'h02);
    wr(1, CTRL, 8'h01);
    check("R7 owner kept", 32'(grant_loc), 1);
    release_and_expect(1, 3);
    wr(3, CTRL, 8'h02);
    repeat (3) @(negedge clk);
    check("R7 nothing left pending", 32'(grant_en), 0);
  endtask

  task automatic t_decode();
    logic [31:0] v;
    wr(5, CTRL, 8'h01);
    wr(7, CTRL, 8'h01);
    wr(0, STATE, 8'h01);
    wr(0, 'h010, 8'h01);
    repeat (3) @(negedge clk);
    check("R2 ignored writes", 32'(grant_en), 0);
    rd(5, STATE, v); check("R2 out-of-range read", v, 0);
    rd(0, CTRL, v);  check("R2 non-state read", v, 0);
    wr(0, CTRL, 8'h01);
    @(negedge clk);
    check("R2 valid write accepted", 32'(grant_en), 1);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_priority();
    t_nonowner();
    t_decode();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule